// File: doc/BRIEF.md
# Script Load/Store Instruction Executor

This block executes one two-word load/store instruction. Such an instruction moves between one and four bytes between a location in system memory and an internal chip register, without going through the general memory-move datapath. A sequencer pulses `start` with both instruction words. The block then:

- latches the words and decodes the direction, addressing mode, byte count and register address;
- forms a 64-bit memory byte address and checks the transfer for legality;
- runs one byte-enabled access on a request/acknowledge memory bus and, for a load, one write into the register file.

Data lanes are never shifted. A byte at memory lane *i* lands in register lane *i*, which is why the register and memory alignment must agree.

The sequencer is a Moore machine with six states:

- **IDLE** waits for `start`, latching the words, and then moves to DECODE.
- **DECODE** evaluates the legality checks. An illegal instruction goes straight to DONE. A legal store captures the register read data. Either legal direction then moves to REQ.
- **REQ** raises `mem_req`. An acknowledge here goes to WB for a load or to DONE for a store. With no acknowledge it moves to WAIT.
- **WAIT** holds the request until an acknowledge arrives, with the same exits as REQ.
- **WB** writes the captured read data into the register file and moves to DONE.
- **DONE** raises `done` for one cycle, together with `illegal` if the instruction was rejected, and returns to IDLE.

Top module: `lsx_exec`

## Requirements
- R1: During and straight after reset, `mem_req`, `reg_we`, `done` and `illegal` are all 0.
- R2: Word 0 field positions are as follows. Bit 24 = 1 means load (memory to register) and 0 means store. Bit 28 selects base-relative mode. Bits 23:16 hold the register byte address and bits 2:0 hold the byte count. With bit 28 clear, the low 32 bits of `mem_addr` equal word 1.
- R3: With bit 28 set, the low 32 bits of `mem_addr` equal `base_addr` + word 1, modulo 2^32.
- R4: The upper 32 bits of `mem_addr` come from `ld_upper` on a load and from `st_upper` on a store.
- R5: `mem_be` bit *i* is set exactly when off <= i < off + count, where off = `mem_addr[1:0]`.
- R6: A store issues `mem_we` = 1, with `mem_wdata` equal to `reg_rdata` as read at `reg_addr` during decode.
- R7: A load writes `mem_rdata` as captured at the acknowledge into the register file. This happens with one `reg_we` cycle, where `reg_be` = `mem_be` and `reg_addr` = word 0 bits 23:16, in the cycle after the acknowledge.
- R8: A count of 0 or above 4 is illegal.
- R9: `reg_addr[1:0]` different from `mem_addr[1:0]` is illegal.
- R10: off + count > 4 (crossing a 32-bit word) is illegal.
- R11: An address whose bits 63:WIN_BITS equal those of `SELF_BASE` (the self-mapped window) is illegal.
- R12: `mem_req` rises two cycles after the `start` edge and stays high, with a stable address, until `mem_ack`. `done` is a single-cycle pulse.
- R13: An illegal instruction pulses `done` and `illegal` one cycle after decode and makes no bus request and no register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Instruction words valid; accepted in IDLE |
| word0 | input | 32 | First instruction word |
| word1 | input | 32 | Second instruction word: address or offset |
| base_addr | input | 32 | Data-structure base register |
| ld_upper | input | 32 | Upper address half for loads |
| st_upper | input | 32 | Upper address half for stores |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (store) |
| mem_addr | output | 64 | Memory byte address |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| reg_addr | output | 8 | Register file byte address |
| reg_rdata | input | 32 | Register file read data (combinational) |
| reg_we | output | 1 | Register file write |
| reg_be | output | 4 | Register file byte enables |
| reg_wdata | output | 32 | Register file write data |
| done | output | 1 | Completion pulse |
| illegal | output | 1 | Rejected instruction, valid with `done` |

## Verification
Each result is due a fixed number of cycles after the `start` edge:

- A rejected instruction shows `done` and `illegal` one edge after decode, which is two edges after `start`.
- A legal one shows `mem_req` two edges after `start`.
- A load shows its register write one edge after the acknowledge edge, with `done` one edge later.
- A store shows `done` one edge after the acknowledge.

Every scenario task drives inputs on falling edges and counts falling edges to land on exactly those cycles. On the rejected paths, and during inserted wait states, it also checks that the signals that must stay quiet or stable do so.

// File: rtl/lsx_pkg.sv
package lsx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_DECODE,
        S_REQ,
        S_WAIT,
        S_WB,
        S_DONE
    } lsx_state_e;

    localparam int DIR_BIT = 24;
    localparam int REL_BIT = 28;
    localparam int CNT_LSB = 0;
    localparam int CNT_W   = 3;
    localparam int RA_LSB  = 16;
endpackage

// File: rtl/lsx_decode.sv
module lsx_decode
    import lsx_pkg::*;
#(
    parameter int          WW        = 32,
    parameter int          RAW       = 8,
    parameter logic [63:0] SELF_BASE = 64'h0000_0000_FEDC_0000,
    parameter int          WIN_BITS  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture_i,
    input  logic [WW-1:0]    word0_i,
    input  logic [WW-1:0]    word1_i,
    input  logic [WW-1:0]    base_i,
    input  logic [WW-1:0]    ld_upper_i,
    input  logic [WW-1:0]    st_upper_i,
    output logic             is_load_o,
    output logic [RAW-1:0]   reg_addr_o,
    output logic [2*WW-1:0]  addr_o,
    output logic [WW/8-1:0]  be_o,
    output logic             illegal_o
);
    localparam int LANES = WW / 8;
    localparam int OFFW  = $clog2(LANES);

    logic [WW-1:0]    w0_q, w1_q;
    logic [CNT_W-1:0] cnt;
    logic [WW-1:0]    lo_addr;
    logic [OFFW-1:0]  off;
    logic [CNT_W:0]   span;
    logic             bad_cnt, bad_align, bad_cross, bad_self;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w0_q <= '0;
            w1_q <= '0;
        end else if (capture_i) begin
            w0_q <= word0_i;
            w1_q <= word1_i;
        end
    end

    always_comb begin
        cnt        = w0_q[CNT_LSB +: CNT_W];
        is_load_o  = w0_q[DIR_BIT];
        reg_addr_o = w0_q[RA_LSB +: RAW];
        lo_addr    = w0_q[REL_BIT] ? (base_i + w1_q) : w1_q;
        addr_o     = {(is_load_o ? ld_upper_i : st_upper_i), lo_addr};
        off        = lo_addr[OFFW-1:0];
        span       = {{(CNT_W+1-OFFW){1'b0}}, off} + {1'b0, cnt};
        bad_cnt    = (cnt == '0) || (int'(cnt) > LANES);
        bad_align  = reg_addr_o[OFFW-1:0] != off;
        bad_cross  = int'(span) > LANES;
        bad_self   = addr_o[2*WW-1:WIN_BITS] == SELF_BASE[2*WW-1:WIN_BITS];
        illegal_o  = bad_cnt || bad_align || bad_cross || bad_self;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign be_o[i] = (i >= int'(off)) && (i < int'(span));
    end

    // R5
    be_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !illegal_o |-> ($countones(be_o) == int'(cnt)));
endmodule

// File: rtl/lsx_fsm.sv
module lsx_fsm
    import lsx_pkg::*;
#(
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          illegal_i,
    input  logic          is_load_i,
    input  logic          mem_ack_i,
    input  logic [WW-1:0] mem_rdata_i,
    input  logic [WW-1:0] reg_rdata_i,
    output logic          capture_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic          reg_we_o,
    output logic [WW-1:0] data_o,
    output logic          done_o,
    output logic          illegal_o
);
    lsx_state_e    state_q, state_d;
    logic [WW-1:0] data_q;
    logic          err_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_DECODE;
            S_DECODE: state_d = illegal_i ? S_DONE : S_REQ;
            S_REQ,
            S_WAIT:   if (mem_ack_i) state_d = is_load_i ? S_WB : S_DONE;
                      else           state_d = S_WAIT;
            S_WB:     state_d = S_DONE;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            data_q  <= '0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_DECODE) begin
                err_q <= illegal_i;
                if (!is_load_i) data_q <= reg_rdata_i;
            end
            if ((state_q == S_REQ || state_q == S_WAIT) && mem_ack_i && is_load_i)
                data_q <= mem_rdata_i;
        end
    end

    always_comb begin
        capture_o = (state_q == S_IDLE) && start_i;
        mem_req_o = (state_q == S_REQ) || (state_q == S_WAIT);
        mem_we_o  = mem_req_o && !is_load_i;
        reg_we_o  = (state_q == S_WB);
        done_o    = (state_q == S_DONE);
        illegal_o = done_o && err_q;
        data_o    = data_q;
    end

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R13
    no_access_bad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o || reg_we_o) |-> !illegal_i);
    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> mem_req_o);
    // R7
    wb_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> ($past(mem_ack_i) && is_load_i));
endmodule

// File: rtl/lsx_exec.sv
module lsx_exec
    import lsx_pkg::*;
#(
    parameter int          WW        = 32,
    parameter int          RAW       = 8,
    parameter logic [63:0] SELF_BASE = 64'h0000_0000_FEDC_0000,
    parameter int          WIN_BITS  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WW-1:0]    word0,
    input  logic [WW-1:0]    word1,
    input  logic [WW-1:0]    base_addr,
    input  logic [WW-1:0]    ld_upper,
    input  logic [WW-1:0]    st_upper,
    output logic             mem_req,
    output logic             mem_we,
    output logic [2*WW-1:0]  mem_addr,
    output logic [WW/8-1:0]  mem_be,
    output logic [WW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [WW-1:0]    mem_rdata,
    output logic [RAW-1:0]   reg_addr,
    input  logic [WW-1:0]    reg_rdata,
    output logic             reg_we,
    output logic [WW/8-1:0]  reg_be,
    output logic [WW-1:0]    reg_wdata,
    output logic             done,
    output logic             illegal
);
    logic          capture, is_load, dec_bad;
    logic [WW-1:0] data;

    lsx_decode #(
        .WW(WW), .RAW(RAW), .SELF_BASE(SELF_BASE), .WIN_BITS(WIN_BITS)
    ) u_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture_i  (capture),
        .word0_i    (word0),
        .word1_i    (word1),
        .base_i     (base_addr),
        .ld_upper_i (ld_upper),
        .st_upper_i (st_upper),
        .is_load_o  (is_load),
        .reg_addr_o (reg_addr),
        .addr_o     (mem_addr),
        .be_o       (mem_be),
        .illegal_o  (dec_bad)
    );

    lsx_fsm #(.WW(WW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start),
        .illegal_i   (dec_bad),
        .is_load_i   (is_load),
        .mem_ack_i   (mem_ack),
        .mem_rdata_i (mem_rdata),
        .reg_rdata_i (reg_rdata),
        .capture_o   (capture),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .reg_we_o    (reg_we),
        .data_o      (data),
        .done_o      (done),
        .illegal_o   (illegal)
    );

    assign mem_wdata = data;
    assign reg_wdata = data;
    assign reg_be    = mem_be;

    // R12
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && $past(mem_req) && !$past(mem_ack)) |-> ($stable(mem_addr) && $stable(mem_be)));
endmodule

// File: tb/sim_lsx_exec.sv
module sim_lsx_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] word0 = '0, word1 = '0, base_addr = '0;
    logic [31:0] ld_upper = 32'h0000_0022, st_upper = 32'h0000_0011;
    logic        mem_req, mem_we, mem_ack = 1'b0;
    logic [63:0] mem_addr;
    logic [3:0]  mem_be, reg_be;
    logic [31:0] mem_wdata, mem_rdata = '0, reg_rdata, reg_wdata;
    logic [7:0]  reg_addr;
    logic        reg_we, done, illegal;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign reg_rdata = {reg_addr, ~reg_addr, 8'h5A, reg_addr ^ 8'hC3};

    lsx_exec u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .word0(word0), .word1(word1),
        .base_addr(base_addr), .ld_upper(ld_upper), .st_upper(st_upper),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .reg_addr(reg_addr), .reg_rdata(reg_rdata), .reg_we(reg_we),
        .reg_be(reg_be), .reg_wdata(reg_wdata), .done(done), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_w0(input bit ld, input bit rel,
                                          input logic [7:0] ra, input logic [2:0] cnt);
        return (32'(rel) << 28) | (32'(ld) << 24) | (32'(ra) << 16) | 32'(cnt);
    endfunction

    function automatic logic [31:0] model_reg(input logic [7:0] a);
        return {a, ~a, 8'h5A, a ^ 8'hC3};
    endfunction

    task automatic run_op(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] base, input bit exp_bad,
                          input logic [63:0] exp_addr, input logic [3:0] exp_be,
                          input logic [31:0] rdata, input int waits, input string tag);
        bit ld;
        logic [7:0] ra;
        ld = w0[24];
        ra = w0[23:16];
        @(negedge clk);
        word0 = w0; word1 = w1; base_addr = base; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!mem_req && !done, {tag, " R12 decode cycle quiet"}, {62'd0, mem_req, done}, 64'd0);
        @(negedge clk);
        if (exp_bad) begin
            check(done && illegal, {tag, " R13 done+illegal"}, {62'd0, done, illegal}, 64'd3);
            check(!mem_req && !reg_we, {tag, " R13 no access"}, {62'd0, mem_req, reg_we}, 64'd0);
            @(negedge clk);
            check(!done && !illegal && !mem_req && !reg_we, {tag, " R13 after"},
                  {60'd0, done, illegal, mem_req, reg_we}, 64'd0);
            return;
        end
        check(mem_req == 1'b1, {tag, " R12 req timing"}, {63'd0, mem_req}, 64'd1);
        check(mem_addr == exp_addr, {tag, " R2 R3 R4 address"}, mem_addr, exp_addr);
        check(mem_be == exp_be, {tag, " R5 byte enables"}, {60'd0, mem_be}, {60'd0, exp_be});
        check(mem_we == !ld, {tag, " R6 write flag"}, {63'd0, mem_we}, {63'd0, !ld});
        if (!ld)
            check(mem_wdata == model_reg(ra), {tag, " R6 store data"},
                  {32'd0, mem_wdata}, {32'd0, model_reg(ra)});
        for (int k = 0; k < waits; k++) begin
            @(negedge clk);
            check(mem_req && mem_addr == exp_addr && mem_be == exp_be && !done,
                  {tag, " R12 held request"}, mem_addr, exp_addr);
        end
        mem_ack = 1'b1; mem_rdata = rdata;
        @(negedge clk);
        mem_ack = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        if (ld) begin
            check(reg_we && !done, {tag, " R7 write-back cycle"}, {62'd0, reg_we, done}, 64'd2);
            check(reg_wdata == rdata, {tag, " R7 write data"}, {32'd0, reg_wdata}, {32'd0, rdata});
            check(reg_be == exp_be && reg_addr == ra, {tag, " R7 lanes/addr"},
                  {52'd0, reg_be, reg_addr}, {52'd0, exp_be, ra});
            @(negedge clk);
        end
        check(done && !illegal && !mem_req && !reg_we, {tag, " R12 done pulse"},
              {60'd0, done, illegal, mem_req, reg_we}, 64'd8);
        @(negedge clk);
        check(!done, {tag, " R12 done single"}, {63'd0, done}, 64'd0);
    endtask

    task automatic t_reset();
        check(!mem_req && !reg_we && !done && !illegal, "R1 reset outputs",
              {60'd0, mem_req, reg_we, done, illegal}, 64'd0);
    endtask

    task automatic t_store_abs();
        run_op(mk_w0(0, 0, 8'h30, 3'd4), 32'h0000_2000, 32'h0, 0,
               {32'h0000_0011, 32'h0000_2000}, 4'b1111, 32'h0, 0, "store_abs R2 R4 R6");
    endtask

    task automatic t_load_abs();
        run_op(mk_w0(1, 0, 8'h4A, 3'd2), 32'h0000_1002, 32'h0, 0,
               {32'h0000_0022, 32'h0000_1002}, 4'b1100, 32'h1234_5678, 0, "load_abs R4 R7");
    endtask

    task automatic t_load_rel();
        run_op(mk_w0(1, 1, 8'h11, 3'd3), 32'h0000_0011, 32'h8000_0FF0, 0,
               {32'h0000_0022, 32'h8000_1001}, 4'b1110, 32'hCAFE_F00D, 0, "load_rel R3");
    endtask

    task automatic t_store_rel_wait();
        run_op(mk_w0(0, 1, 8'h0B, 3'd1), 32'h0000_0003, 32'hFFFF_FFF8, 0,
               {32'h0000_0011, 32'hFFFF_FFFB}, 4'b1000, 32'h0, 3, "store_rel_wait R3 R12");
    endtask

    task automatic t_bad_count();
        run_op(mk_w0(1, 0, 8'h20, 3'd0), 32'h0000_0100, 32'h0, 1, '0, '0, '0, 0, "count0 R8");
        run_op(mk_w0(0, 0, 8'h20, 3'd5), 32'h0000_0100, 32'h0, 1, '0, '0, '0, 0, "count5 R8");
    endtask

    task automatic t_bad_align();
        run_op(mk_w0(1, 0, 8'h21, 3'd1), 32'h0000_0102, 32'h0, 1, '0, '0, '0, 0, "misalign R9");
    endtask

    task automatic t_bad_cross();
        run_op(mk_w0(0, 0, 8'h22, 3'd3), 32'h0000_0102, 32'h0, 1, '0, '0, '0, 0, "cross R10");
        run_op(mk_w0(0, 0, 8'h22, 3'd2), 32'h0000_0102, 32'h0, 0,
               {32'h0000_0011, 32'h0000_0102}, 4'b1100, 32'h0, 0, "edge fit R10");
    endtask

    task automatic t_self_window();
        st_upper = 32'h0;
        run_op(mk_w0(0, 0, 8'h04, 3'd4), 32'hFEDC_0104, 32'h0, 1, '0, '0, '0, 0, "self R11");
        st_upper = 32'h0000_0001;
        run_op(mk_w0(0, 0, 8'h04, 3'd4), 32'hFEDC_0104, 32'h0, 0,
               {32'h0000_0001, 32'hFEDC_0104}, 4'b1111, 32'h0, 0, "outside self R11");
        st_upper = 32'h0000_0011;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store_abs();
        t_load_abs();
        t_load_rel();
        t_store_rel_wait();
        t_bad_count();
        t_bad_align();
        t_bad_cross();
        t_self_window();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule